// File: doc/BRIEF.md
# Upset-Tolerant Data Register with Single-Error Correction

This block holds one byte of data together with five redundancy bits. When the block is loaded, an encoder forms four Hamming parity bits and one overall parity bit from the incoming byte and stores them next to the data in a 13-bit word. The read side is purely combinational. It recomputes the syndrome from the stored word, repairs any single flipped bit before the byte reaches the output, and flags a double flip as uncorrectable. A read never alters the stored word, and the block does not write corrected values back to storage on its own.

A test port can flip any chosen set of stored bits on a clock edge. A fault-injection harness uses this port to mimic single-event upsets and to measure what the output side observes.

Top module: `seu_reg`

## Requirements
- R1: A synchronous reset clears all 13 stored bits. After the reset, `q` reads 0x00 and `err` reads 00.
- R2: On a rising clock edge with `ce` high, the register stores `d`. From then on, `q` equals that byte and `err` is 00.
- R3: When `ce` and `flip_en` are both low, the stored word is held. Reads do not change it, so `q` and `err` stay stable.
- R4: The stored word places the data byte at bits [12:5], the Hamming parity bits at [4:1] and the overall parity bit at [0]. `flip_mask` bit n toggles stored bit n.
- R5: A single flip in any data position [12:5] of a valid word is corrected. `q` shows the written byte and `err` is 01.
- R6: A single flip in any redundancy position [4:0] is also reported as 01, and `q` still shows the written byte.
- R7: Any two flipped bits in a valid word give `err` = 10. In that case `q` shows the stored data bits [12:5] without correction.
- R8: `err` never takes the reserved value 11.
- R9: On an edge where `ce` is high, the write takes priority and `flip_en` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Write enable for the data byte |
| d | input | DW | Data to store |
| flip_en | input | 1 | Applies `flip_mask` to the stored word |
| flip_mask | input | DW+PW+1 | Stored bits to toggle |
| q | output | DW | Corrected data |
| err | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |

## Verification
The bench uses the default 8-bit data width. At this width the full input space is small enough to cover completely. Every one of the 256 byte values is written, and each of the 13 stored bits is flipped and then restored. All 78 two-bit flip pairs are applied to every byte value, so correction and double-error detection are checked at every syndrome the code can produce.

// File: rtl/seu_reg.sv
module seu_reg #(
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ce,
  input  logic [DW-1:0]        d,
  input  logic                 flip_en,
  input  logic [DW+$clog2(DW+$clog2(DW)+1):0] flip_mask,
  output logic [DW-1:0]        q,
  output logic [1:0]           err
);
  localparam int PW = $clog2(DW + $clog2(DW) + 1);
  localparam int NP = DW + PW;
  localparam int SW = NP + 1;

  function automatic int dpos(int i);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 1; p <= NP; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == i) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

  function automatic logic [PW-1:0] hgen(logic [DW-1:0] dv);
    logic [PW-1:0] h;
    int pos;
    h = '0;
    for (int i = 0; i < DW; i++) begin
      pos = dpos(i);
      for (int k = 0; k < PW; k++)
        if (pos[k]) h[k] = h[k] ^ dv[i];
    end
    return h;
  endfunction

  logic [SW-1:0] st;
  logic [DW-1:0] info, fix;
  logic [PW-1:0] syn;
  logic          par;

  always_ff @(posedge clk) begin
    if (rst)          st <= '0;
    else if (ce)      st <= {d, hgen(d), ^{d, hgen(d)}};
    else if (flip_en) st <= st ^ flip_mask;
  end

  assign info = st[SW-1:PW+1];
  assign syn  = st[PW:1] ^ hgen(info);
  assign par  = ^st;

  always_comb begin
    for (int i = 0; i < DW; i++)
      fix[i] = (int'(syn) == dpos(i));
  end

  always_comb begin
    if (!par && syn == '0)         err = 2'b00;
    else if (par && int'(syn) <= NP) err = 2'b01;
    else                           err = 2'b10;
  end

  assign q = (err == 2'b01) ? (info ^ fix) : info;

  p_reset_clear_r1: assert property (@(posedge clk) $fell(rst) |-> (q == '0 && err == 2'b00));
  p_write_clean_r2: assert property (@(posedge clk) disable iff (rst)
    ce |=> (q == $past(d) && err == 2'b00));
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!ce && !flip_en) |=> ($stable(q) && $stable(err)));
  p_single_fix_r5: assert property (@(posedge clk) disable iff (rst)
    (!ce && flip_en && $countones(flip_mask) == 1 && err == 2'b00) |=> (err == 2'b01 && q == $past(q)));
  p_double_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (!ce && flip_en && $countones(flip_mask) == 2 && err == 2'b00) |=> (err == 2'b10));
  p_no_reserved_r8: assert property (@(posedge clk) disable iff (rst) err != 2'b11);
endmodule

// File: tb/seu_reg_tb.sv
module seu_reg_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        ce = 0;
  logic [7:0]  d = '0;
  logic        flip_en = 0;
  logic [12:0] flip_mask = '0;
  logic [7:0]  q;
  logic [1:0]  err;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  seu_reg #(.DW(8)) u_dut (.clk(clk), .rst(rst), .ce(ce), .d(d), .flip_en(flip_en),
                           .flip_mask(flip_mask), .q(q), .err(err));

  always #4 clk = ~clk;

  task automatic chk(string req, logic [7:0] eq, logic [1:0] ee);
    checks++;
    if (q !== eq || err !== ee) begin
      fails++;
      $display("FAIL %s: q=%h err=%b expected q=%h err=%b", req, q, err, eq, ee);
    end
  endtask

  task automatic wr(logic [7:0] v);
    @(negedge clk); ce = 1; d = v;
    @(negedge clk); ce = 0;
  endtask

  task automatic flip(logic [12:0] m);
    @(negedge clk); flip_en = 1; flip_mask = m;
    @(negedge clk); flip_en = 0; flip_mask = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1", 8'h00, 2'b00);
    wr(8'hA5);
    chk("R2", 8'hA5, 2'b00);
    repeat (3) @(negedge clk);
    chk("R3", 8'hA5, 2'b00);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R1", 8'h00, 2'b00);
    @(negedge clk); ce = 1; d = 8'h3C; flip_en = 1; flip_mask = 13'h1FFF;
    @(negedge clk); ce = 0; flip_en = 0; flip_mask = '0;
    chk("R9", 8'h3C, 2'b00);
    for (int v = 0; v < 256; v++) begin
      wr(v[7:0]);
      chk("R2", v[7:0], 2'b00);
      for (int b = 0; b < 13; b++) begin
        flip(13'(1) << b);
        if (b < 5) chk("R6", v[7:0], 2'b01);
        else       chk("R5", v[7:0], 2'b01);
        @(negedge clk);
        chk("R3", v[7:0], 2'b01);
        flip(13'(1) << b);
        chk("R4", v[7:0], 2'b00);
      end
      for (int a = 0; a < 13; a++)
        for (int b = a + 1; b < 13; b++) begin
          logic [12:0] m;
          m = (13'(1) << a) | (13'(1) << b);
          flip(m);
          chk("R7", v[7:0] ^ m[12:5], 2'b10);
          flip(m);
        end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule